// File: doc/BRIEF.md
# Register-Indirect Add Execution Unit

This unit carries out one instruction of a small 16-bit processor: add a word fetched from memory, at the address held in one register, to a second register. The unit holds the processor's eight 16-bit registers and its four arithmetic status bits. It fetches the operand through a request/acknowledge read port. It then writes the sum back and moves the address register by that register's own rule. Registers 1 to 3 hold still, registers 4, 5 and 7 step up after each read, and register 6 steps down before each read, acting as a stack pointer.

A one-shot double-byte prefix, armed by a pulse on `dbl_arm`, turns the next instruction into a two-read form. The low byte of each read is kept, and the two bytes are joined into the 16-bit operand. The prefix is dropped when that instruction completes. The length of the instruction is set by its form, not by the speed of memory: `busy` stays high for a fixed number of cycles, and `done` marks the last one. An encoding this unit does not execute raises `unhandled` in the cycle it is offered, and nothing changes.

A host loads and inspects registers through a plain write port and a combinational read port. Both are meant for use while the unit is idle.

Top module: `idxadd_unit`

## Requirements
- R1: A `start` in an idle cycle is accepted only when `instr[15:6]` equals 10'b0000001010 and `instr[5:3]` is not 000. Any other word raises `unhandled` in that same cycle, and it leaves registers, flags, prefix and `busy` unchanged.
- R2: Without the prefix, one read is made at the address computed from register `instr[5:3]`. The whole 16-bit word read is added to register `instr[2:0]`, and the sum replaces that register.
- R3: With the prefix armed, two reads are made. Bits [7:0] of the first read form operand bits [7:0], and bits [7:0] of the second read form operand bits [15:8].
- R4: When register 1, 2 or 3 is the address register, it is not modified, and both reads of a prefixed instruction use the same address.
- R5: When register 4, 5 or 7 is the address register, each read uses its current value, and the register then advances by one.
- R6: When register 6 is the address register, it is lowered by one before each read, and the read uses the lowered value.
- R7: Counting the cycle after the accepting edge as cycle 1, `done` is high in cycle 10 for a prefixed instruction. It is high in cycle 11 for an unprefixed one through register 6, and in cycle 8 for the rest. `busy` is high from cycle 1 through that cycle. This holds as long as every read is acknowledged in time.
- R8: On completion the flags take these values: sign is result bit 15, zero is set when the 16-bit result is 0, carry is the carry out of bit 15, and overflow is set when both addends share a sign that the result does not.
- R9: `dbl_arm` sets the prefix only in an idle cycle that accepts no instruction. The prefix is cleared in the cycle after `done`.
- R10: `rd_req` is high only while busy. Once raised, it stays high with `rd_addr` unchanged until `rd_ack` is seen.
- R11: The destination addend is the register value at acceptance. When the destination is also the address register, the sum overrides the address update.
- R12: While busy, `start`, `dbl_arm` and `reg_we` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Offer `instr` for execution |
| instr | input | 16 | Instruction word |
| dbl_arm | input | 1 | Arm the double-byte prefix |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 16 | Read data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| unhandled | output | 1 | Offered word is not executed here |
| dbl_active | output | 1 | Prefix currently armed |
| flag_sign | output | 1 | Sign status bit |
| flag_zero | output | 1 | Zero status bit |
| flag_ovf | output | 1 | Overflow status bit |
| flag_carry | output | 1 | Carry status bit |
| reg_we | input | 1 | Host register write enable |
| reg_wsel | input | 3 | Host write register index |
| reg_wdata | input | 16 | Host write data |
| reg_rsel | input | 3 | Host read register index |
| reg_rdata | output | 16 | Host read data, combinational |

## Verification
Suppose the address tracked inside the unit drifts, for example a missing step or a step in the wrong direction. The read port shows the error on the very next request, and the address register shows it on readback one cycle after `done`. A fault in how the bytes are joined, or in the sum, appears in the destination register and the four flags in the cycle after `done`. A miscounted phase counter moves `done` away from cycle 8, 10 or 11. Phase sequencing faults show up as a missing or extra read in the request log, or as a prefix that is still armed after completion.

// File: rtl/idxadd_pkg.sv
package idxadd_pkg;

    localparam int IW      = 16;
    localparam int NREG    = 8;
    localparam int SW      = 3;
    localparam logic [9:0] OPC_HI = 10'b0000001010;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RD_LO,
        PH_RD_HI,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        AM_NONE,
        AM_FIXED,
        AM_POSTINC,
        AM_PREDEC
    } amode_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic ovf;
        logic carry;
    } flags_t;

    function automatic amode_e addr_mode(input logic [SW-1:0] f);
        amode_e m;
        case (f)
            3'd0:                m = AM_NONE;
            3'd1, 3'd2, 3'd3:    m = AM_FIXED;
            3'd6:                m = AM_PREDEC;
            default:             m = AM_POSTINC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/idxadd_regfile.sv
module idxadd_regfile
    import idxadd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_we,
    input  logic [SW-1:0] ext_sel,
    input  logic [DW-1:0] ext_wdata,
    input  logic          a_we,
    input  logic [SW-1:0] a_sel,
    input  logic [DW-1:0] a_wdata,
    input  logic          d_we,
    input  logic [SW-1:0] d_sel,
    input  logic [DW-1:0] d_wdata,
    input  logic [SW-1:0] rp0_sel,
    output logic [DW-1:0] rp0_data,
    input  logic [SW-1:0] rp1_sel,
    output logic [DW-1:0] rp1_data,
    input  logic [SW-1:0] rp2_sel,
    output logic [DW-1:0] rp2_data
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    // Priority: destination write, then address update, then host port.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (ext_we && ext_sel == SW'(i)) regs_d[i] = ext_wdata;
            if (a_we && a_sel == SW'(i))     regs_d[i] = a_wdata;
            if (d_we && d_sel == SW'(i))     regs_d[i] = d_wdata;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end
    end

    assign rp0_data = regs_q[rp0_sel];
    assign rp1_data = regs_q[rp1_sel];
    assign rp2_data = regs_q[rp2_sel];

endmodule

// File: rtl/idxadd_alu.sv
module idxadd_alu
    import idxadd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] add_a,
    input  logic [DW-1:0] add_b,
    output logic [DW-1:0] sum,
    output flags_t        flg
);

    logic [DW:0] wide;

    always_comb begin
        wide      = {1'b0, add_a} + {1'b0, add_b};
        sum       = wide[DW-1:0];
        flg.carry = wide[DW];
        flg.sign  = wide[DW-1];
        flg.zero  = (wide[DW-1:0] == '0);
        flg.ovf   = (add_a[DW-1] == add_b[DW-1]) && (wide[DW-1] != add_a[DW-1]);
    end

endmodule

// File: rtl/idxadd_seq.sv
module idxadd_seq
    import idxadd_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CYC_BASE  = 8,
    parameter int CYC_STACK = 11,
    parameter int CYC_DBL   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] instr,
    input  logic          dbl_arm,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic [DW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic          unhandled,
    output logic          dbl_active,
    output flags_t        flags,
    output logic [SW-1:0] a_sel,
    input  logic [DW-1:0] a_rdata,
    output logic [SW-1:0] d_sel,
    input  logic [DW-1:0] d_rdata,
    output logic          a_we,
    output logic [DW-1:0] a_wdata,
    output logic          d_we,
    output logic [DW-1:0] add_a,
    output logic [DW-1:0] add_b,
    input  flags_t        alu_flg
);

    localparam int HB   = DW / 2;
    localparam int CM1  = (CYC_BASE > CYC_DBL) ? CYC_BASE : CYC_DBL;
    localparam int CMAX = (CM1 > CYC_STACK) ? CM1 : CYC_STACK;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [SW-1:0] aidx;
        logic [SW-1:0] didx;
        logic [DW-1:0] addr;
        logic [DW-1:0] dval;
        logic [DW-1:0] op;
        logic          dbl;
        logic          pre;
        flags_t        fl;
    } st_t;

    st_t           st_q, st_d;
    logic          valid;
    amode_e        mode_q;
    amode_e        mode_in;
    logic [CW-1:0] target;

    always_comb begin
        valid   = (instr[15:6] == OPC_HI) && (instr[5:3] != '0);
        mode_q  = addr_mode(st_q.aidx);
        mode_in = addr_mode(instr[5:3]);
        if (st_q.dbl)                target = CW'(CYC_DBL);
        else if (mode_q == AM_PREDEC) target = CW'(CYC_STACK);
        else                         target = CW'(CYC_BASE);
    end

    always_comb begin
        st_d      = st_q;
        rd_req    = 1'b0;
        done      = 1'b0;
        unhandled = 1'b0;
        a_we      = 1'b0;
        d_we      = 1'b0;

        if (st_q.ph != PH_IDLE && st_q.cnt < target) st_d.cnt = st_q.cnt + 1'b1;

        case (st_q.ph)
            PH_IDLE: begin
                if (start && valid) begin
                    st_d.ph   = PH_RD_LO;
                    st_d.cnt  = CW'(1);
                    st_d.aidx = instr[5:3];
                    st_d.didx = instr[2:0];
                    st_d.addr = (mode_in == AM_PREDEC) ? a_rdata - 1'b1 : a_rdata;
                    st_d.dval = d_rdata;
                    st_d.op   = '0;
                    st_d.dbl  = st_q.pre;
                end else begin
                    if (start) unhandled = 1'b1;
                    if (dbl_arm) st_d.pre = 1'b1;
                end
            end
            PH_RD_LO: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    if (st_q.dbl) begin
                        st_d.op = {{(DW-HB){1'b0}}, rd_data[HB-1:0]};
                        st_d.ph = PH_RD_HI;
                        if (mode_q == AM_PREDEC) st_d.addr = st_q.addr - 1'b1;
                    end else begin
                        st_d.op = rd_data;
                        st_d.ph = PH_HOLD;
                    end
                    if (mode_q == AM_POSTINC) st_d.addr = st_q.addr + 1'b1;
                end
            end
            PH_RD_HI: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    st_d.op[DW-1:HB] = rd_data[HB-1:0];
                    st_d.ph          = PH_HOLD;
                    if (mode_q == AM_POSTINC) st_d.addr = st_q.addr + 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == target) begin
                    done    = 1'b1;
                    a_we    = (mode_q == AM_POSTINC) || (mode_q == AM_PREDEC);
                    d_we    = 1'b1;
                    st_d.fl = alu_flg;
                    st_d.pre = 1'b0;
                    st_d.ph  = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.ph != PH_IDLE);
    assign rd_addr    = st_q.addr;
    assign dbl_active = st_q.pre;
    assign flags      = st_q.fl;
    assign a_sel      = busy ? st_q.aidx : instr[5:3];
    assign d_sel      = busy ? st_q.didx : instr[2:0];
    assign a_wdata    = st_q.addr;
    assign add_a      = st_q.dval;
    assign add_b      = st_q.op;

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R10
    AST_BASE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy, 7)); // R7
    AST_DBL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.dbl) |-> $past(busy, 9)); // R7
    AST_STACK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.dbl && mode_q == AM_PREDEC) |-> $past(busy, 10)); // R7
    AST_PREFIX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!dbl_active && !busy)); // R9
    AST_UNHANDLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |=> !busy); // R1
    AST_ARM_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dbl_active) |=> !dbl_active); // R12

endmodule

// File: rtl/idxadd_unit.sv
module idxadd_unit
    import idxadd_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CYC_BASE  = 8,
    parameter int CYC_STACK = 11,
    parameter int CYC_DBL   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] instr,
    input  logic          dbl_arm,
    output logic          rd_req,
    output logic [DW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          unhandled,
    output logic          dbl_active,
    output logic          flag_sign,
    output logic          flag_zero,
    output logic          flag_ovf,
    output logic          flag_carry,
    input  logic          reg_we,
    input  logic [SW-1:0] reg_wsel,
    input  logic [DW-1:0] reg_wdata,
    input  logic [SW-1:0] reg_rsel,
    output logic [DW-1:0] reg_rdata
);

    logic [SW-1:0] a_sel, d_sel;
    logic [DW-1:0] a_rdata, d_rdata, a_wdata;
    logic [DW-1:0] add_a, add_b, sum;
    logic          a_we, d_we;
    flags_t        alu_flg, flags;

    idxadd_seq #(
        .DW(DW), .CYC_BASE(CYC_BASE), .CYC_STACK(CYC_STACK), .CYC_DBL(CYC_DBL)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .dbl_arm(dbl_arm),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .done(done), .unhandled(unhandled), .dbl_active(dbl_active),
        .flags(flags), .a_sel(a_sel), .a_rdata(a_rdata), .d_sel(d_sel),
        .d_rdata(d_rdata), .a_we(a_we), .a_wdata(a_wdata), .d_we(d_we),
        .add_a(add_a), .add_b(add_b), .alu_flg(alu_flg)
    );

    idxadd_alu #(.DW(DW)) i_alu (
        .add_a(add_a), .add_b(add_b), .sum(sum), .flg(alu_flg)
    );

    idxadd_regfile #(.DW(DW)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .ext_we(reg_we && !busy), .ext_sel(reg_wsel), .ext_wdata(reg_wdata),
        .a_we(a_we), .a_sel(a_sel), .a_wdata(a_wdata),
        .d_we(d_we), .d_sel(d_sel), .d_wdata(sum),
        .rp0_sel(a_sel), .rp0_data(a_rdata),
        .rp1_sel(d_sel), .rp1_data(d_rdata),
        .rp2_sel(reg_rsel), .rp2_data(reg_rdata)
    );

    assign flag_sign  = flags.sign;
    assign flag_zero  = flags.zero;
    assign flag_ovf   = flags.ovf;
    assign flag_carry = flags.carry;

endmodule

// File: tb/test_idxadd_unit.sv
`timescale 1ns/1ps
module test_idxadd_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        dbl_arm = 1'b0;
    logic        rd_req, rd_ack;
    logic [15:0] rd_addr, rd_data;
    logic        busy, done, unhandled, dbl_active;
    logic        flag_sign, flag_zero, flag_ovf, flag_carry;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_wsel = '0, reg_rsel = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_total = 0;
    int ack_delay = 0;
    int hold_cnt = 0;
    int rd_n = 0;
    logic [15:0] rd_log [64];
    logic [15:0] mem [16];
    logic [15:0] mdl [8];
    logic        prev_stall = 1'b0;
    logic [15:0] prev_addr = '0;

    always #2 clk = ~clk;

    idxadd_unit i_idxadd_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .dbl_arm(dbl_arm),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .unhandled(unhandled), .dbl_active(dbl_active),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
        .flag_carry(flag_carry), .reg_we(reg_we), .reg_wsel(reg_wsel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata)
    );

    // Memory model: acknowledge after ack_delay waiting cycles.
    assign rd_ack  = rd_req && (hold_cnt >= ack_delay);
    assign rd_data = mem[rd_addr[3:0]];

    always @(posedge clk) begin
        if (rd_req && !rd_ack) hold_cnt <= hold_cnt + 1;
        else                   hold_cnt <= 0;
        if (rd_req && rd_ack) begin
            rd_log[rd_n % 64] <= rd_addr;
            rd_n <= rd_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R10: a stalled request must persist with the same address.
    always @(negedge clk) begin
        if (rst_n && prev_stall)
            chk(rd_req && rd_addr == prev_addr, "R10 request held", {15'd0, rd_req, rd_addr}, {16'd1, prev_addr});
        prev_stall <= rd_req && !rd_ack;
        prev_addr  <= rd_addr;
    end

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_reg(input int idx, input logic [15:0] v);
        reg_we = 1'b1; reg_wsel = 3'(idx); reg_wdata = v;
        tick();
        reg_we = 1'b0;
        mdl[idx] = v;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 8; i++) begin
            reg_rsel = 3'(i);
            #0.5;
            chk(reg_rdata == mdl[i], tag, {16'd0, reg_rdata}, {16'd0, mdl[i]});
        end
    endtask

    function automatic logic [3:0] flagcalc(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] w;
        w = {1'b0, a} + {1'b0, b};
        return {w[15], w[15:0] == 16'd0, (a[15] == b[15]) && (w[15] != a[15]), w[16]};
    endfunction

    // Runs one add, predicting addresses, operand, result, flags and length.
    task automatic do_add(input logic [2:0] aaa, input logic [2:0] ddd, input bit dbl,
                          input bit disturb, input string tag);
        logic [15:0] a, op, res, d1, d2;
        logic [15:0] ea [2];
        logic [3:0]  ef;
        bit inc, dec;
        int nr, ecyc, cyc, base;
        inc = (aaa == 3'd4) || (aaa == 3'd5) || (aaa == 3'd7);
        dec = (aaa == 3'd6);
        if (dbl) begin
            dbl_arm = 1'b1; tick(); dbl_arm = 1'b0;
            chk(dbl_active == 1'b1, {tag, " R9 armed"}, {31'd0, dbl_active}, 32'd1);
        end
        nr = dbl ? 2 : 1;
        a = mdl[aaa];
        for (int k = 0; k < nr; k++) begin
            if (dec) a = a - 1'b1;
            ea[k] = a;
            if (inc) a = a + 1'b1;
        end
        if (!dbl) ea[1] = ea[0];
        d1 = mem[ea[0][3:0]];
        d2 = mem[ea[1][3:0]];
        op = dbl ? {d2[7:0], d1[7:0]} : d1;
        res = mdl[ddd] + op;
        ef = flagcalc(mdl[ddd], op);
        ecyc = dbl ? 10 : (dec ? 11 : 8);
        base = rd_n;
        instr = {10'b0000001010, aaa, ddd};
        start = 1'b1;
        tick();
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            if (disturb && cyc == 3) begin
                start = 1'b1; instr = {10'b0000001010, 3'd1, 3'd0};
                dbl_arm = 1'b1; reg_we = 1'b1; reg_wsel = 3'd0; reg_wdata = 16'hDEAD;
            end else begin
                start = 1'b0; dbl_arm = 1'b0; reg_we = 1'b0;
            end
            tick();
            cyc++;
        end
        start = 1'b0; dbl_arm = 1'b0; reg_we = 1'b0;
        chk(cyc == ecyc, {tag, " R7 cycles to done"}, cyc, ecyc);
        chk(busy == 1'b1, {tag, " R7 busy through last cycle"}, {31'd0, busy}, 32'd1);
        tick();
        if (inc || dec) mdl[aaa] = a;
        mdl[ddd] = res;
        chk(rd_n - base == nr, {tag, " R2/R3 read count"}, rd_n - base, nr);
        for (int k = 0; k < nr; k++)
            chk(rd_log[(base + k) % 64] == ea[k], {tag, " R4/R5/R6 read address"},
                {16'd0, rd_log[(base + k) % 64]}, {16'd0, ea[k]});
        check_regs({tag, " R2/R11 register file"});
        chk({flag_sign, flag_zero, flag_ovf, flag_carry} == ef, {tag, " R8 flags"},
            {28'd0, flag_sign, flag_zero, flag_ovf, flag_carry}, {28'd0, ef});
        chk(!dbl_active && !busy, {tag, " R9 prefix cleared"}, {30'd0, dbl_active, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !rd_req && !dbl_active, "R7 reset idle",
            {28'd0, busy, done, rd_req, dbl_active}, 32'd0);
        chk({flag_sign, flag_zero, flag_ovf, flag_carry} == 4'd0, "R8 reset flags",
            {28'd0, flag_sign, flag_zero, flag_ovf, flag_carry}, 32'd0);
        check_regs("R2 reset registers");
    endtask

    task automatic t_single_modes();
        set_reg(4, 16'h1003); set_reg(0, 16'h1234);
        do_add(3'd4, 3'd0, 1'b0, 1'b0, "postinc R5");
        set_reg(1, 16'h2007); set_reg(3, 16'h0100);
        do_add(3'd1, 3'd3, 1'b0, 1'b0, "fixed R4");
        set_reg(6, 16'h0040); set_reg(2, 16'h0FF0);
        do_add(3'd6, 3'd2, 1'b0, 1'b0, "stack R6");
    endtask

    task automatic t_double_modes();
        set_reg(7, 16'h000E); set_reg(5, 16'h0001);
        do_add(3'd7, 3'd5, 1'b1, 1'b0, "double postinc R3");
        set_reg(2, 16'h0009); set_reg(0, 16'h0000);
        do_add(3'd2, 3'd0, 1'b1, 1'b0, "double fixed R4");
        set_reg(6, 16'h0001); set_reg(4, 16'h7000);
        do_add(3'd6, 3'd4, 1'b1, 1'b0, "double stack R6");
        do_add(3'd4, 3'd1, 1'b0, 1'b0, "after double R9 single length");
    endtask

    task automatic t_flags();
        mem[3] = 16'h0001;
        set_reg(3, 16'h0003); set_reg(0, 16'h7FFF);
        do_add(3'd3, 3'd0, 1'b0, 1'b0, "overflow R8");
        mem[3] = 16'h0001;
        set_reg(1, 16'hFFFF);
        do_add(3'd3, 3'd1, 1'b0, 1'b0, "carry zero R8");
        mem[3] = 16'h8000;
        set_reg(2, 16'h8000);
        do_add(3'd3, 3'd2, 1'b0, 1'b0, "neg overflow R8");
    endtask

    task automatic t_same_reg();
        set_reg(5, 16'h0004);
        do_add(3'd5, 3'd5, 1'b0, 1'b0, "dest is address R11");
    endtask

    task automatic t_unhandled();
        instr = {10'b0000001010, 3'd0, 3'd2};
        start = 1'b1;
        #0.5;
        chk(unhandled == 1'b1, "R1 direct form flagged", {31'd0, unhandled}, 32'd1);
        tick();
        instr = 16'h02F1 ^ 16'h4000;
        #0.5;
        chk(unhandled == 1'b1, "R1 foreign opcode flagged", {31'd0, unhandled}, 32'd1);
        tick();
        start = 1'b0;
        chk(!busy && !rd_req, "R1 nothing started", {30'd0, busy, rd_req}, 32'd0);
        check_regs("R1 registers unchanged");
    endtask

    task automatic t_busy_ignore();
        set_reg(4, 16'h0002); set_reg(3, 16'h0011);
        do_add(3'd4, 3'd3, 1'b0, 1'b1, "inputs while busy R12");
    endtask

    task automatic t_slow_memory();
        ack_delay = 3;
        set_reg(5, 16'h000A); set_reg(1, 16'h0202);
        do_add(3'd5, 3'd1, 1'b0, 1'b0, "slow single R10");
        set_reg(7, 16'h0005);
        do_add(3'd7, 3'd2, 1'b1, 1'b0, "slow double R10");
        ack_delay = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h1111 * 16'(i) ^ 16'hA5C3;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single_modes();
        t_double_modes();
        t_flags();
        t_same_reg();
        t_unhandled();
        t_busy_ignore();
        t_slow_memory();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule